// File: doc/BRIEF.md
# Four-Channel PWM Configuration Register Bank

This block is the software-visible register file of a four-channel pulse-width modulation controller. A host reaches it over a plain 32-bit word bus: a byte address, a write strobe with write data, and a read strobe whose data comes back on the next cycle. The block stores the settings that the prescaler, the clock dividers and the waveform generators need. It drives those settings out as flat configuration ports. It also tells each channel when its own settings change.

Every channel has three registers: a period count, a compare value and a count capture. The capture register is read-only. It samples the live counter that the waveform generator supplies. Period and compare writes saturate at the 16-bit maximum instead of dropping high bits. The bank also shares three registers across channels: a prescaler word, a clock-select word and a control word. In the control word each channel owns a 4-bit field. The watchdog slots and the two interrupt slots accept writes and read as zero. Misaligned accesses, unmapped addresses and writes to the capture registers raise an error pulse.

Top module: `pwm_cfg_bank`

## Requirements
- R1: After reset, every stored register is zero. Every configuration output is zero. `bus_rdata`, `bus_err` and `upd_strb` are zero.
- R2: The prescaler word sits at byte offset 0x00, the clock-select word at 0x04 and the control word at 0x08. Each holds all 32 written bits, reads them back and drives them on `cfg_prescale`, `cfg_clksel` and `cfg_ctrl`.
- R3: For channel n (0 to 3), the period count is at 0x0C+12n and the compare value at 0x10+12n. Each is 16 bits wide, reads back zero-extended, and appears at bits [16n+15:16n] of `cfg_cnt` and `cfg_cmp`.
- R4: A write above 65535 to a period or compare register stores 65535.
- R5: The capture register of channel n is at 0x14+12n. It returns `live_cnt[16n+15:16n]` as sampled one clock earlier. A write to it changes nothing and raises `bus_err`.
- R6: The watchdog slots at 0x44, 0x48, 0x4C and 0x50, interrupt enable at 0x3C and interrupt status at 0x40 accept writes without error. They always read zero.
- R7: An access whose address has nonzero low two bits, or that falls on no mapped offset, raises `bus_err`. A read of it returns zero and a write of it changes no register.
- R8: `bus_rdata` carries read data in the cycle after `bus_rd`. It is zero in any cycle not preceded by a read. `bus_err` is a one-cycle pulse in the cycle after the offending access.
- R9: `upd_strb[n]` pulses for one cycle, after the write, when that write changes the stored value of channel n's period count, its compare value or its control field. Control field bit positions are [3:0] for channel 0, [11:8] for channel 1, [15:12] for channel 2 and [19:16] for channel 3. Rewriting an equal value gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the bank |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_err | output | 1 | One-cycle invalid-access pulse |
| live_cnt | input | 64 | Live counter of each channel, 16 bits per channel |
| cfg_prescale | output | 32 | Prescaler word |
| cfg_clksel | output | 32 | Clock-select word |
| cfg_ctrl | output | 32 | Control word |
| cfg_cnt | output | 64 | Period count per channel |
| cfg_cmp | output | 64 | Compare value per channel |
| upd_strb | output | 4 | Per-channel settings-changed pulse |

## Verification
The assertions assume that the host never raises `bus_rd` and `bus_wr` in the same cycle. With both raised, the single read-data register and the error pulse could not be tied to one access. Every vector in the bench table therefore carries exactly one operation, or none. Inputs change only on the falling clock edge, so each access lasts exactly one cycle. `live_cnt` is held constant, so the one-cycle capture delay cannot blur the expected capture values.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   // Byte offsets of the shared registers
   localparam int OFS_PRESC  = 'h00;
   localparam int OFS_CLKSEL = 'h04;
   localparam int OFS_CTRL   = 'h08;
   localparam int OFS_IEN    = 'h3C;
   localparam int OFS_ISTAT  = 'h40;
   localparam int OFS_WDOG   = 'h44;

   // Per-channel block: period, compare, capture at a fixed stride
   localparam int OFS_CH_BASE  = 'h0C;
   localparam int CH_STRIDE    = 12;
   localparam int CH_CMP_DELTA = 4;
   localparam int CH_CAP_DELTA = 8;

   localparam int CTL_FIELD_W = 4;

   typedef enum logic [3:0] {
      K_NONE, K_PRESC, K_CLKSEL, K_CTRL,
      K_CNT, K_CMP, K_CAP, K_WDOG, K_IEN, K_ISTAT
   } reg_kind_e;

   // Lowest bit of the control field that belongs to channel n
   function automatic int ctl_lsb(input int n);
      return (n == 0) ? 0 : 4 + 4 * n;
   endfunction

endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
   import pwm_bank_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int NUM_CH = 4,
   localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic [CH_IW-1:0]  ch
);

   always_comb begin
      kind = K_NONE;
      ch   = '0;
      if (addr[1:0] == 2'b00) begin
         if (addr == ADDR_W'(OFS_PRESC))       kind = K_PRESC;
         else if (addr == ADDR_W'(OFS_CLKSEL)) kind = K_CLKSEL;
         else if (addr == ADDR_W'(OFS_CTRL))   kind = K_CTRL;
         else if (addr == ADDR_W'(OFS_IEN))    kind = K_IEN;
         else if (addr == ADDR_W'(OFS_ISTAT))  kind = K_ISTAT;
         for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(OFS_CH_BASE + CH_STRIDE * n)) begin
               kind = K_CNT;
               ch   = CH_IW'(n);
            end
            if (addr == ADDR_W'(OFS_CH_BASE + CH_STRIDE * n + CH_CMP_DELTA)) begin
               kind = K_CMP;
               ch   = CH_IW'(n);
            end
            if (addr == ADDR_W'(OFS_CH_BASE + CH_STRIDE * n + CH_CAP_DELTA)) begin
               kind = K_CAP;
               ch   = CH_IW'(n);
            end
            if (addr == ADDR_W'(OFS_WDOG + 4 * n)) begin
               kind = K_WDOG;
               ch   = CH_IW'(n);
            end
         end
      end
   end

endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int CTL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_cnt,
   input  logic              we_cmp,
   input  logic              we_ctl,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CTL_W-1:0]  ctl_cur,
   input  logic [CTL_W-1:0]  ctl_new,
   input  logic [CNT_W-1:0]  live,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CNT_W-1:0]  cmp_q,
   output logic [CNT_W-1:0]  cap_q,
   output logic              strb_q
);

   localparam logic [CNT_W-1:0]  SAT_MAX  = '1;
   localparam logic [DATA_W-1:0] SAT_WIDE = DATA_W'(SAT_MAX);

   logic [CNT_W-1:0] sat_val;
   logic             changed;

   // Oversized values saturate rather than wrap
   assign sat_val = (wdata > SAT_WIDE) ? SAT_MAX : wdata[CNT_W-1:0];

   assign changed = (we_cnt && sat_val != cnt_q) ||
                    (we_cmp && sat_val != cmp_q) ||
                    (we_ctl && ctl_new != ctl_cur);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cmp_q  <= '0;
         cap_q  <= '0;
         strb_q <= 1'b0;
      end else begin
         if (we_cnt) cnt_q <= sat_val;
         if (we_cmp) cmp_q <= sat_val;
         cap_q  <= live;
         strb_q <= changed;
      end
   end

   assert_cnt_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_cnt && wdata > SAT_WIDE) |=> cnt_q == SAT_MAX);

   assert_cmp_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we_cmp && wdata > SAT_WIDE) |=> cmp_q == SAT_MAX);

   assert_strobe_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      strb_q |-> (cnt_q != $past(cnt_q)) || (cmp_q != $past(cmp_q)) ||
                 (ctl_cur != $past(ctl_cur)));

endmodule

// File: rtl/pwm_bank_rdmux.sv
module pwm_bank_rdmux
   import pwm_bank_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 4,
   localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  reg_kind_e                      kind,
   input  logic [CH_IW-1:0]               ch,
   input  logic [DATA_W-1:0]              presc,
   input  logic [DATA_W-1:0]              clksel,
   input  logic [DATA_W-1:0]              ctrl,
   input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt,
   input  logic [NUM_CH-1:0][CNT_W-1:0]   cmp,
   input  logic [NUM_CH-1:0][CNT_W-1:0]   cap,
   output logic [DATA_W-1:0]              rd_val
);

   always_comb begin
      case (kind)
         K_PRESC:  rd_val = presc;
         K_CLKSEL: rd_val = clksel;
         K_CTRL:   rd_val = ctrl;
         K_CNT:    rd_val = DATA_W'(cnt[ch]);
         K_CMP:    rd_val = DATA_W'(cmp[ch]);
         K_CAP:    rd_val = DATA_W'(cap[ch]);
         default:  rd_val = '0;
      endcase
   end

endmodule

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank
   import pwm_bank_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic [DATA_W-1:0]        bus_wdata,
   input  logic                     bus_rd,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     bus_err,
   input  logic [NUM_CH*CNT_W-1:0]  live_cnt,
   output logic [DATA_W-1:0]        cfg_prescale,
   output logic [DATA_W-1:0]        cfg_clksel,
   output logic [DATA_W-1:0]        cfg_ctrl,
   output logic [NUM_CH*CNT_W-1:0]  cfg_cnt,
   output logic [NUM_CH*CNT_W-1:0]  cfg_cmp,
   output logic [NUM_CH-1:0]        upd_strb
);

   localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("NUM_CH must be 1 to 4 to fit the address map");
   end
   if (CNT_W >= DATA_W) begin : g_bad_cnt
      $error("CNT_W must be narrower than DATA_W");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for the map");
   end
   if (ctl_lsb(NUM_CH - 1) + CTL_FIELD_W > DATA_W) begin : g_bad_ctl
      $error("control fields exceed the data width");
   end

   reg_kind_e                    kind;
   logic [CH_IW-1:0]             ch;
   logic [DATA_W-1:0]            presc_q, clksel_q, ctrl_q, rdata_q, rd_val;
   logic                         err_q, wr_ok, err_next;
   logic [NUM_CH-1:0][CNT_W-1:0] cnt_a, cmp_a, cap_a;

   pwm_bank_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .addr (bus_addr),
      .kind (kind),
      .ch   (ch)
   );

   assign wr_ok    = bus_wr && kind != K_NONE && kind != K_CAP;
   assign err_next = ((bus_rd || bus_wr) && kind == K_NONE) ||
                     (bus_wr && kind == K_CAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         presc_q  <= '0;
         clksel_q <= '0;
         ctrl_q   <= '0;
         rdata_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         if (wr_ok && kind == K_PRESC)  presc_q  <= bus_wdata;
         if (wr_ok && kind == K_CLKSEL) clksel_q <= bus_wdata;
         if (wr_ok && kind == K_CTRL)   ctrl_q   <= bus_wdata;
         rdata_q <= (bus_rd && kind != K_NONE) ? rd_val : '0;
         err_q   <= err_next;
      end
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam int LSB = ctl_lsb(n);
      logic sel_ch;
      assign sel_ch = (ch == CH_IW'(n));

      pwm_chan_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CTL_W(CTL_FIELD_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .we_cnt  (wr_ok && kind == K_CNT && sel_ch),
         .we_cmp  (wr_ok && kind == K_CMP && sel_ch),
         .we_ctl  (wr_ok && kind == K_CTRL),
         .wdata   (bus_wdata),
         .ctl_cur (ctrl_q[LSB +: CTL_FIELD_W]),
         .ctl_new (bus_wdata[LSB +: CTL_FIELD_W]),
         .live    (live_cnt[n*CNT_W +: CNT_W]),
         .cnt_q   (cnt_a[n]),
         .cmp_q   (cmp_a[n]),
         .cap_q   (cap_a[n]),
         .strb_q  (upd_strb[n])
      );
   end

   pwm_bank_rdmux #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_rdmux (
      .kind   (kind),
      .ch     (ch),
      .presc  (presc_q),
      .clksel (clksel_q),
      .ctrl   (ctrl_q),
      .cnt    (cnt_a),
      .cmp    (cmp_a),
      .cap    (cap_a),
      .rd_val (rd_val)
   );

   assign bus_rdata    = rdata_q;
   assign bus_err      = err_q;
   assign cfg_prescale = presc_q;
   assign cfg_clksel   = clksel_q;
   assign cfg_ctrl     = ctrl_q;
   assign cfg_cnt      = cnt_a;
   assign cfg_cmp      = cmp_a;

   assert_err_follows_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_rd || bus_wr));

   assert_cap_write_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && kind == K_CAP) |=> bus_err);

   assert_rdata_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_rd) |-> bus_rdata == '0);

   assert_shared_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_wr) |-> ($stable(cfg_prescale) && $stable(cfg_clksel) && $stable(cfg_ctrl)));

   assert_no_rd_wr_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

endmodule

// File: tb/pwm_cfg_bank_tb.sv
module pwm_cfg_bank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic [63:0] live_cnt = {16'hA003, 16'hA002, 16'hA001, 16'hA000};
   logic [31:0] cfg_prescale, cfg_clksel, cfg_ctrl;
   logic [63:0] cfg_cnt, cfg_cmp;
   logic [3:0]  upd_strb;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pwm_cfg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .live_cnt(live_cnt), .cfg_prescale(cfg_prescale),
      .cfg_clksel(cfg_clksel), .cfg_ctrl(cfg_ctrl), .cfg_cnt(cfg_cnt),
      .cfg_cmp(cfg_cmp), .upd_strb(upd_strb)
   );

   // op(2: 1=write 2=read) addr(12) wdata(32) exp_rdata(32) exp_err(1) exp_strb(4) req(4)
   localparam int NV = 35;
   localparam logic [86:0] VEC [NV] = '{
      {2'd1, 12'h000, 32'h12345678, 32'h0,        1'b0, 4'b0000, 4'd2}, // R2
      {2'd2, 12'h000, 32'h0,        32'h12345678, 1'b0, 4'b0000, 4'd2}, // R2
      {2'd1, 12'h004, 32'h00004321, 32'h0,        1'b0, 4'b0000, 4'd2}, // R2
      {2'd2, 12'h004, 32'h0,        32'h00004321, 1'b0, 4'b0000, 4'd2}, // R2
      {2'd1, 12'h00C, 32'h00000100, 32'h0,        1'b0, 4'b0001, 4'd3}, // R3
      {2'd2, 12'h00C, 32'h0,        32'h00000100, 1'b0, 4'b0000, 4'd3}, // R3
      {2'd1, 12'h028, 32'h00000055, 32'h0,        1'b0, 4'b0100, 4'd3}, // R3
      {2'd2, 12'h028, 32'h0,        32'h00000055, 1'b0, 4'b0000, 4'd3}, // R3
      {2'd1, 12'h030, 32'h00012345, 32'h0,        1'b0, 4'b1000, 4'd4}, // R4
      {2'd2, 12'h030, 32'h0,        32'h0000FFFF, 1'b0, 4'b0000, 4'd4}, // R4
      {2'd1, 12'h034, 32'hFFFFFFFF, 32'h0,        1'b0, 4'b1000, 4'd4}, // R4
      {2'd2, 12'h034, 32'h0,        32'h0000FFFF, 1'b0, 4'b0000, 4'd4}, // R4
      {2'd1, 12'h030, 32'h00020000, 32'h0,        1'b0, 4'b0000, 4'd9}, // R9 same saturated value
      {2'd1, 12'h014, 32'h00001234, 32'h0,        1'b1, 4'b0000, 4'd5}, // R5
      {2'd2, 12'h014, 32'h0,        32'h0000A000, 1'b0, 4'b0000, 4'd5}, // R5
      {2'd2, 12'h02C, 32'h0,        32'h0000A002, 1'b0, 4'b0000, 4'd5}, // R5
      {2'd1, 12'h044, 32'hFFFFFFFF, 32'h0,        1'b0, 4'b0000, 4'd6}, // R6
      {2'd2, 12'h044, 32'h0,        32'h0,        1'b0, 4'b0000, 4'd6}, // R6
      {2'd1, 12'h03C, 32'h0000FFFF, 32'h0,        1'b0, 4'b0000, 4'd6}, // R6
      {2'd2, 12'h03C, 32'h0,        32'h0,        1'b0, 4'b0000, 4'd6}, // R6
      {2'd1, 12'h040, 32'h000000FF, 32'h0,        1'b0, 4'b0000, 4'd6}, // R6
      {2'd2, 12'h040, 32'h0,        32'h0,        1'b0, 4'b0000, 4'd6}, // R6
      {2'd1, 12'h008, 32'h00000009, 32'h0,        1'b0, 4'b0001, 4'd9}, // R9
      {2'd1, 12'h008, 32'h00001009, 32'h0,        1'b0, 4'b0100, 4'd9}, // R9
      {2'd1, 12'h008, 32'h00001009, 32'h0,        1'b0, 4'b0000, 4'd9}, // R9
      {2'd1, 12'h008, 32'h000F1009, 32'h0,        1'b0, 4'b1000, 4'd9}, // R9
      {2'd1, 12'h008, 32'h000F1109, 32'h0,        1'b0, 4'b0010, 4'd9}, // R9
      {2'd2, 12'h008, 32'h0,        32'h000F1109, 1'b0, 4'b0000, 4'd2}, // R2
      {2'd2, 12'h054, 32'h0,        32'h0,        1'b1, 4'b0000, 4'd7}, // R7
      {2'd2, 12'h00E, 32'h0,        32'h0,        1'b1, 4'b0000, 4'd7}, // R7
      {2'd1, 12'h00D, 32'h00000007, 32'h0,        1'b1, 4'b0000, 4'd7}, // R7
      {2'd2, 12'h00C, 32'h0,        32'h00000100, 1'b0, 4'b0000, 4'd7}, // R7
      {2'd1, 12'h018, 32'h00000000, 32'h0,        1'b0, 4'b0000, 4'd9}, // R9
      {2'd1, 12'h7FC, 32'hDEADBEEF, 32'h0,        1'b1, 4'b0000, 4'd7}, // R7
      {2'd1, 12'h008, 32'h000F11F9, 32'h0,        1'b0, 4'b0000, 4'd9}  // R9
   };

   task automatic check32(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic idle_check(input string req);
      check32(req, "rdata/err/strb idle", {27'd0, bus_rdata, bus_err, upd_strb},
              64'd0);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check32("R1", "prescale", {32'd0, cfg_prescale}, 64'd0);
      check32("R1", "clksel", {32'd0, cfg_clksel}, 64'd0);
      check32("R1", "ctrl", {32'd0, cfg_ctrl}, 64'd0);
      check32("R1", "cnt", cfg_cnt, 64'd0);
      check32("R1", "cmp", cfg_cmp, 64'd0);
      idle_check("R1");

      // vector table, one bus cycle per entry (R8 timing)
      for (int i = 0; i < NV; i++) begin
         logic [86:0] v;
         logic [63:0] act, exp;
         v = VEC[i];
         bus_wr    = (v[86:85] == 2'd1);
         bus_rd    = (v[86:85] == 2'd2);
         bus_addr  = v[84:73];
         bus_wdata = v[72:41];
         @(negedge clk);
         act = {27'd0, bus_rdata, bus_err, upd_strb};
         exp = {27'd0, v[40:9], v[8], v[7:4]};
         checks++;
         if (act !== exp) begin
            fails++;
            $display("FAIL R%0d vector %0d addr %h: actual rdata/err/strb %h expected %h",
                     v[3:0], i, v[84:73], act, exp);
         end
         bus_wr = 1'b0;
         bus_rd = 1'b0;
      end

      @(negedge clk);
      idle_check("R8");
      check32("R2", "prescale port", {32'd0, cfg_prescale}, 64'h12345678);
      check32("R2", "clksel port", {32'd0, cfg_clksel}, 64'h4321);
      check32("R9", "ctrl port", {32'd0, cfg_ctrl}, 64'h000F11F9);
      check32("R3", "cnt port", cfg_cnt, {16'hFFFF, 16'h0, 16'h0, 16'h0100});
      check32("R4", "cmp port", cfg_cmp, {16'hFFFF, 16'h0055, 16'h0, 16'h0});

      // R1: reset in mid-run clears everything
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check32("R1", "cnt after reset", cfg_cnt, 64'd0);
      check32("R1", "ctrl after reset", {32'd0, cfg_ctrl}, 64'd0);
      bus_rd = 1'b1; bus_addr = 12'h034;
      @(negedge clk);
      bus_rd = 1'b0;
      check32("R1", "cmp3 read after reset", {32'd0, bus_rdata}, 64'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         $display("FAIL R8 watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule